// File: doc/BRIEF.md
# Paged Byte RAM on the External Data Bus

This block puts a 1 KiB byte-wide data store on a microcontroller's external data bus. It also holds a small page control register on the special-function-register (SFR) bus. The bus master reaches the store in two ways.

- A long-form access supplies a full 16-bit address.
- A short-form access supplies only an 8-bit offset. The page control register then provides the upper address bits.

Only the low ten bits of the effective address select a byte. The store therefore repeats every 0x400 bytes across the whole 64 KiB space. This lets software run a linear fill past the end of the store without reloading its pointer.

Writes to the store and to the page register take effect on the clock edge at which the strobe is sampled. Read data from either bus is registered and appears one cycle after the read strobe. A new page value is used by a short-form access in the cycle right after the register write.

Top module: `paged_xram`

## Requirements
- R1: After reset the page register holds 0, `sfr_rdata` is 0x00 and `mem_rdata` is 0x00.
- R2: A byte written through the data bus is returned on `mem_rdata` in the cycle after a read strobe to the same effective address.
- R3: A long-form access (`mem_short`=0) selects byte `mem_addr[9:0]`, and `mem_addr[15:10]` has no effect. For example, 0x0000, 0x0400, 0x0800 and 0xFC00 all reach the same byte.
- R4: A short-form access (`mem_short`=1) selects byte {page, `mem_addr[7:0]`}, and `mem_addr[15:8]` has no effect.
- R5: Page value 0 covers bytes 0x000–0x0FF, value 1 covers 0x100–0x1FF, value 2 covers 0x200–0x2FF and value 3 covers 0x300–0x3FF.
- R6: The page register answers at SFR address 0xAF. Writes load its bits [1:0]. Reads return the page in bits [1:0]. Bits [7:2] always read 0, even after writing 0xFF.
- R7: An SFR write to any other address leaves the page unchanged. An SFR read of any other address returns 0x00 in the next cycle.
- R8: A short-form access in the cycle right after a page register write uses the new page.
- R9: When read and write strobes hit the same byte in one cycle, the read returns the byte's previous contents and the write still takes effect.
- R10: `mem_rdata` keeps its value in every cycle after one with no data-bus read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | input | 16 | Data-bus address; only bits [7:0] are used in short form |
| mem_short | input | 1 | 1 = short-form (paged) access, 0 = long-form access |
| mem_rd | input | 1 | Data-bus read strobe |
| mem_wr | input | 1 | Data-bus write strobe |
| mem_wdata | input | 8 | Data-bus write byte |
| mem_rdata | output | 8 | Data-bus read byte, valid one cycle after `mem_rd` |
| sfr_addr | input | 8 | SFR-bus address |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write byte |
| sfr_rdata | output | 8 | SFR read byte, valid one cycle after `sfr_rd` |

## Verification
The assertions assume that `rst_n` is low before the first clock edge. They also assume that strobes are sampled only at rising edges, with inputs stable around them. The bench meets both conditions: it starts in reset and changes every input only at falling edges.

Random SFR addresses are biased towards the page register but still hit other addresses, which exercises the decode in both directions. Data-bus addresses use all sixteen bits, so the ignored upper bits always carry random values.

// File: rtl/paged_xram_pkg.sv
package paged_xram_pkg;
    localparam int unsigned ADDR_W_DEF     = 16;
    localparam int unsigned DATA_W_DEF     = 8;
    localparam int unsigned PAGE_W_DEF     = 2;
    localparam int unsigned OFFS_W_DEF     = 8;
    localparam int unsigned SFR_ADDR_W_DEF = 8;
    localparam logic [SFR_ADDR_W_DEF-1:0] PAGE_SFR_DEF = 8'hAF;

    // Registered state of the page control register.
    typedef struct packed {
        logic [PAGE_W_DEF-1:0] page;
        logic [DATA_W_DEF-1:0] rdata;
    } page_state_t;
endpackage

// File: rtl/xram_addr_map.sv
module xram_addr_map #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 2,
    parameter int unsigned OFFS_W = 8
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     short_i,
    input  logic [PAGE_W-1:0]        page_i,
    output logic [PAGE_W+OFFS_W-1:0] idx_o
);
    localparam int unsigned IDX_W = PAGE_W + OFFS_W;

    // Upper address bits are don't-cares: the store aliases modulo its depth.
    logic unused_hi;
    assign unused_hi = ^addr_i[ADDR_W-1:IDX_W];

    always_comb begin
        if (short_i) begin
            idx_o = {page_i, addr_i[OFFS_W-1:0]};
        end else begin
            idx_o = addr_i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/xram_page_reg.sv
module xram_page_reg
    import paged_xram_pkg::*;
#(
    parameter int unsigned              SFR_ADDR_W = SFR_ADDR_W_DEF,
    parameter logic [SFR_ADDR_W-1:0]    PAGE_SFR   = PAGE_SFR_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SFR_ADDR_W-1:0] sfr_addr_i,
    input  logic                  sfr_rd_i,
    input  logic                  sfr_wr_i,
    input  logic [DATA_W_DEF-1:0] sfr_wdata_i,
    output logic [PAGE_W_DEF-1:0] page_o,
    output logic [DATA_W_DEF-1:0] sfr_rdata_o
);
    localparam int unsigned PAD_W = DATA_W_DEF - PAGE_W_DEF;

    page_state_t st_d, st_q;
    logic        hit;

    // Only the low page bits are stored; the rest of the write byte is dropped.
    logic unused_wdata;
    assign unused_wdata = ^sfr_wdata_i[DATA_W_DEF-1:PAGE_W_DEF];

    assign hit = (sfr_addr_i == PAGE_SFR);

    always_comb begin
        st_d = st_q;
        if (sfr_wr_i && hit) begin
            st_d.page = sfr_wdata_i[PAGE_W_DEF-1:0];
        end
        if (sfr_rd_i && hit) begin
            st_d.rdata = {{PAD_W{1'b0}}, st_q.page};
        end else begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_o      = st_q.page;
    assign sfr_rdata_o = st_q.rdata;
endmodule

// File: rtl/xram_store.sv
module xram_store #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  widx;
        logic [DATA_W-1:0] wbyte;
    } wr_req_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;
    wr_req_t           req_d;

    always_comb begin
        req_d.we    = wr_i;
        req_d.widx  = idx_i;
        req_d.wbyte = wdata_i;
        // Read sees the array before this edge's write (read-before-write).
        rdata_d = rd_i ? mem_q[idx_i] : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    always_ff @(posedge clk) begin
        if (req_d.we) begin
            mem_q[req_d.widx] <= req_d.wbyte;
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/paged_xram.sv
module paged_xram
    import paged_xram_pkg::*;
#(
    parameter int unsigned           ADDR_W     = ADDR_W_DEF,
    parameter int unsigned           SFR_ADDR_W = SFR_ADDR_W_DEF,
    parameter logic [SFR_ADDR_W-1:0] PAGE_SFR   = PAGE_SFR_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_short,
    input  logic                  mem_rd,
    input  logic                  mem_wr,
    input  logic [DATA_W_DEF-1:0] mem_wdata,
    output logic [DATA_W_DEF-1:0] mem_rdata,
    input  logic [SFR_ADDR_W-1:0] sfr_addr,
    input  logic                  sfr_rd,
    input  logic                  sfr_wr,
    input  logic [DATA_W_DEF-1:0] sfr_wdata,
    output logic [DATA_W_DEF-1:0] sfr_rdata
);
    localparam int unsigned IDX_W = PAGE_W_DEF + OFFS_W_DEF;

    logic [PAGE_W_DEF-1:0] page_q;
    logic [IDX_W-1:0]      idx;

    xram_page_reg #(
        .SFR_ADDR_W (SFR_ADDR_W),
        .PAGE_SFR   (PAGE_SFR)
    ) page_reg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfr_addr_i  (sfr_addr),
        .sfr_rd_i    (sfr_rd),
        .sfr_wr_i    (sfr_wr),
        .sfr_wdata_i (sfr_wdata),
        .page_o      (page_q),
        .sfr_rdata_o (sfr_rdata)
    );

    xram_addr_map #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W_DEF),
        .OFFS_W (OFFS_W_DEF)
    ) addr_map_i (
        .addr_i  (mem_addr),
        .short_i (mem_short),
        .page_i  (page_q),
        .idx_o   (idx)
    );

    xram_store #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W_DEF)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (idx),
        .rd_i    (mem_rd),
        .wr_i    (mem_wr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );
endmodule

// File: rtl/paged_xram_chk.sv
module paged_xram_chk
    import paged_xram_pkg::*;
#(
    parameter int unsigned           SFR_ADDR_W = SFR_ADDR_W_DEF,
    parameter logic [SFR_ADDR_W-1:0] PAGE_SFR   = PAGE_SFR_DEF
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mem_rd,
    input logic [DATA_W_DEF-1:0] mem_rdata,
    input logic [SFR_ADDR_W-1:0] sfr_addr,
    input logic                  sfr_rd,
    input logic                  sfr_wr,
    input logic [DATA_W_DEF-1:0] sfr_wdata,
    input logic [DATA_W_DEF-1:0] sfr_rdata,
    input logic [PAGE_W_DEF-1:0] page_q
);
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rdata[DATA_W_DEF-1:PAGE_W_DEF] == '0);

    a_r6_read_page: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && sfr_addr == PAGE_SFR) |=> sfr_rdata[PAGE_W_DEF-1:0] == $past(page_q));

    a_r7_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && sfr_addr != PAGE_SFR) |=> sfr_rdata == '0);

    a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_wr && sfr_addr == PAGE_SFR) |=> $stable(page_q));

    a_r8_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == PAGE_SFR) |=> page_q == $past(sfr_wdata[PAGE_W_DEF-1:0]));

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> $stable(mem_rdata));
endmodule

bind paged_xram paged_xram_chk #(
    .SFR_ADDR_W (SFR_ADDR_W),
    .PAGE_SFR   (PAGE_SFR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .sfr_addr  (sfr_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .page_q    (page_q)
);

// File: tb/paged_xram_tb_top.sv
module paged_xram_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr = '0;
    logic        mem_short = 1'b0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic [7:0]  mem_wdata = '0;
    logic [7:0]  mem_rdata;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_rd = 1'b0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] model [1024];
    logic [1:0] page_m = 2'd0;
    logic [7:0] last_rd = 8'h00;

    always #4 clk = ~clk;

    paged_xram dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_short(mem_short), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    function automatic logic [9:0] eff(input logic [15:0] a, input logic s);
        return s ? {page_m, a[7:0]} : a[9:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic mwrite(input logic [15:0] a, input logic s, input logic [7:0] d);
        mem_addr = a; mem_short = s; mem_wdata = d; mem_wr = 1'b1;
        @(negedge clk);
        mem_wr = 1'b0;
        model[eff(a, s)] = d;
    endtask

    task automatic mread(input logic [15:0] a, input logic s, input string req);
        logic [7:0] exp;
        exp = model[eff(a, s)];
        mem_addr = a; mem_short = s; mem_rd = 1'b1;
        @(negedge clk);
        mem_rd = 1'b0;
        last_rd = exp;
        check(req, mem_rdata, exp);
    endtask

    task automatic swrite(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
        if (a == 8'hAF) page_m = d[1:0];
    endtask

    task automatic sread(input logic [7:0] a, input string req);
        logic [7:0] exp;
        exp = (a == 8'hAF) ? {6'b0, page_m} : 8'h00;
        sfr_addr = a; sfr_rd = 1'b1;
        @(negedge clk);
        sfr_rd = 1'b0;
        check(req, sfr_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] old;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mem_rdata", mem_rdata, 8'h00);
        check("R1 sfr_rdata", sfr_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        sread(8'hAF, "R1 page reset");

        // Fill the store through long-form writes
        for (int i = 0; i < 1024; i++) mwrite(16'(i), 1'b0, 8'(i * 7 + 3));
        mread(16'h0005, 1'b0, "R2 readback");

        // R3: aliasing across 0x400 multiples
        mwrite(16'h0000, 1'b0, 8'hA5);
        mread(16'h0400, 1'b0, "R3 alias 0x0400");
        mread(16'h0800, 1'b0, "R3 alias 0x0800");
        mread(16'hFC00, 1'b0, "R3 alias 0xFC00");
        mwrite(16'h7FFF, 1'b0, 8'h3C);
        mread(16'h03FF, 1'b0, "R3 alias top byte");

        // R5/R4: each page through short form, upper address bits junk
        for (int p = 0; p < 4; p++) begin
            swrite(8'hAF, 8'(p));
            mwrite(16'hE712, 1'b1, 8'(8'h40 + p));
            check("R5 page map", model[10'(p * 256 + 8'h12)], 8'(8'h40 + p));
            mread(16'h0012 + 16'(p * 256), 1'b0, "R5 long view of page");
            mread(16'h3312, 1'b1, "R4 short read");
        end

        // R6: upper bits stay zero after all-ones write
        swrite(8'hAF, 8'hFF);
        sread(8'hAF, "R6 all-ones");
        swrite(8'hAF, 8'h02);
        sread(8'hAF, "R6 page 2");

        // R7: other SFR addresses
        swrite(8'hAE, 8'h03);
        sread(8'hAF, "R7 page kept");
        sread(8'hAE, "R7 miss reads zero");

        // R8: page change seen by the very next short access
        mwrite(16'h0155, 1'b0, 8'h11);
        mwrite(16'h0355, 1'b0, 8'h33);
        swrite(8'hAF, 8'h01);
        mread(16'h0055, 1'b1, "R8 next cycle page 1");
        swrite(8'hAF, 8'h03);
        mread(16'h0055, 1'b1, "R8 next cycle page 3");

        // R9: read and write same byte in one cycle
        old = model[10'h2AA];
        mem_addr = 16'h02AA; mem_short = 1'b0; mem_wdata = ~old;
        mem_rd = 1'b1; mem_wr = 1'b1;
        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0;
        check("R9 old data", mem_rdata, old);
        model[10'h2AA] = ~old;
        mread(16'h02AA, 1'b0, "R9 write landed");

        // R10: hold without read strobe
        mwrite(16'h02AA, 1'b0, 8'h77);
        check("R10 hold over write", mem_rdata, last_rd);
        repeat (3) @(negedge clk);
        check("R10 hold idle", mem_rdata, last_rd);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            logic        s;
            a = 16'($urandom);
            s = 1'($urandom);
            case ($urandom % 5)
                0, 1: mwrite(a, s, 8'($urandom));
                2, 3: mread(a, s, s ? "R4 random short" : "R3 random long");
                default: begin
                    logic [7:0] sa;
                    sa = ($urandom % 4 == 0) ? 8'($urandom) : 8'hAF;
                    swrite(sa, 8'($urandom));
                    sread(($urandom % 2 == 0) ? 8'hAF : sa, "R6 random sfr");
                end
            endcase
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule